// File: doc/BRIEF.md
# Byte-Lane and Cycle-Type Signalling Controller

This block sits in the master side of a 16-bit bus whose address and data share one set of pins. For each accepted request it runs the bus through its phases and drives a pair of signals that tell external logic what kind of cycle is in progress. The pair is an active-low high-byte enable and the low address bit of the shared bus. The pair separates word, high-byte, low-byte and refresh cycles. Refresh is marked only on this pair, because the separate address bus may carry a different address during a refresh cycle.

A configuration strap is sampled while reset is held. With the strap high, the address phase on the shared bus can be suppressed for the lower and upper memory regions. Each region has its own disable bit for this. In that case the address appears only on the separate address bus. With the strap low, every cycle drives an address phase. While bus hold is granted, and while reset is active, the lane drivers are released.

Top module: `bus_lane_ctrl`

## Requirements
- R1: After reset the controller is idle: `phase_o` reads 0, `hbe_n_o` reads 1, `a0_o` reads 0. `lane_oe_o` is 0 for as long as `rst_i` is high.
- R2: A request seen on a clock edge while the controller is idle, not in hold and not leaving hold starts a cycle. The phases then step 1 (T1), 2 (T2), 3 (T3) on successive edges. A request seen outside the idle phase is ignored.
- R3: During phases 1 to 4, `{hbe_n_o, a0_o}` encodes the latched request type. Type 0 is word and drives 00. Type 1 is high byte and drives 01. Type 2 is low byte and drives 10. Type 3 is refresh and drives 11.
- R4: At the edge that ends T3, a low `ready_i` moves the controller to phase 4 (wait). The wait phase repeats while `ready_i` stays low. A high `ready_i` at T3 or in a wait phase returns the controller to phase 0.
- R5: `{hbe_n_o, a0_o}` holds its value unchanged from T1 through T3 and every wait phase.
- R6: Bus hold is granted only from idle. A high `hold_i` seen on an edge while idle sets the hold state. The hold state drives `lane_oe_o` to 0 and blocks requests. Hold is released one edge after `hold_i` falls, and only then can a request be accepted.
- R7: `strap_i` is captured on every edge while `rst_i` is high. The value held at the last reset edge is kept until the next reset, and later changes of `strap_i` have no effect.
- R8: `addr_phase_o` is 1 only in T1. It is 0 in T1 when the captured strap is 1 and the cycle's latched region has its disable bit set. Region code 01 is the lower region and uses `dis_lo_i`. Region code 10 is the upper region and uses `dis_up_i`. Region codes 00 and 11 are never suppressed.
- R9: When the captured strap is 0, `addr_phase_o` is 1 in every T1, whatever the disable bits and the region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| strap_i | input | 1 | Address-suppression strap, sampled during reset |
| req_i | input | 1 | Cycle request |
| req_type_i | input | 2 | Cycle type: 0 word, 1 high byte, 2 low byte, 3 refresh |
| region_i | input | 2 | Memory region: 01 lower, 10 upper, else none |
| dis_lo_i | input | 1 | Disable-address bit of the lower region |
| dis_up_i | input | 1 | Disable-address bit of the upper region |
| ready_i | input | 1 | Ready, already synchronized; low inserts wait phases |
| hold_i | input | 1 | Bus hold request |
| hbe_n_o | output | 1 | High-byte enable, active low |
| a0_o | output | 1 | Low address bit of the shared bus |
| lane_oe_o | output | 1 | Drive enable for the lane pins; 0 releases them |
| addr_phase_o | output | 1 | Address is driven on the shared bus in this T1 |
| phase_o | output | 3 | Phase: 0 idle, 1 T1, 2 T2, 3 T3, 4 wait |

## Verification
The assertions check on every cycle:
- the fixed T1 to T2 to T3 order and the exit on ready;
- the stability of the lane pair through T3 and the wait phases;
- release of the drivers under reset;
- the confinement of the address phase to T1, and its forced presence when the strap was low.

Only the bench's scenarios can show some behaviours:
- the type-to-pair mapping and the wait counts;
- that a request is ignored during hold, and the one-edge delay after release;
- that a strap change after reset is ignored;
- the full table of strap, region and disable-bit combinations.

// File: rtl/bus_lane_ctrl.sv
module bus_lane_ctrl #(
  parameter int TYPE_W = 2,
  parameter int REG_W  = 2
) (
  input  logic              clk,
  input  logic              rst_i,
  input  logic              strap_i,
  input  logic              req_i,
  input  logic [TYPE_W-1:0] req_type_i,
  input  logic [REG_W-1:0]  region_i,
  input  logic              dis_lo_i,
  input  logic              dis_up_i,
  input  logic              ready_i,
  input  logic              hold_i,
  output logic              hbe_n_o,
  output logic              a0_o,
  output logic              lane_oe_o,
  output logic              addr_phase_o,
  output logic [2:0]        phase_o
);
  localparam logic [REG_W-1:0] REG_LO = REG_W'(1);
  localparam logic [REG_W-1:0] REG_UP = REG_W'(2);

  typedef enum logic [2:0] {
    S_IDLE = 3'd0, S_T1 = 3'd1, S_T2 = 3'd2, S_T3 = 3'd3, S_TW = 3'd4
  } phase_t;

  phase_t            st;
  logic [TYPE_W-1:0] type_q;
  logic [REG_W-1:0]  reg_q;
  logic              hold_q;
  logic              strap_q;
  logic              active;
  logic              suppress;

  always_ff @(posedge clk) begin
    if (rst_i) begin
      st      <= S_IDLE;
      type_q  <= '0;
      reg_q   <= '0;
      hold_q  <= 1'b0;
      strap_q <= strap_i;
    end else begin
      case (st)
        S_IDLE: begin
          if (hold_i)      hold_q <= 1'b1;
          else if (hold_q) hold_q <= 1'b0;
          else if (req_i) begin
            st     <= S_T1;
            type_q <= req_type_i;
            reg_q  <= region_i;
          end
        end
        S_T1:    st <= S_T2;
        S_T2:    st <= S_T3;
        S_T3:    st <= ready_i ? S_IDLE : S_TW;
        S_TW:    st <= ready_i ? S_IDLE : S_TW;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign active   = (st != S_IDLE);
  assign suppress = strap_q && (((reg_q == REG_LO) && dis_lo_i) ||
                                ((reg_q == REG_UP) && dis_up_i));

  assign hbe_n_o      = active ? type_q[1] : 1'b1;
  assign a0_o         = active ? type_q[0] : 1'b0;
  assign lane_oe_o    = !rst_i && !hold_q;
  assign addr_phase_o = (st == S_T1) && !suppress;
  assign phase_o      = st;
endmodule

module bus_lane_chk (
  input logic       clk,
  input logic       rst_i,
  input logic       ready_i,
  input logic       strap_q,
  input logic       hbe_n_o,
  input logic       a0_o,
  input logic       lane_oe_o,
  input logic       addr_phase_o,
  input logic [2:0] phase_o
);
  // R1
  always @(posedge clk) oe_in_reset_chk: assert (!(rst_i && lane_oe_o));

  // R2
  t1_to_t2_chk: assert property (@(posedge clk) disable iff (rst_i)
    phase_o == 3'd1 |=> phase_o == 3'd2);

  // R2
  t2_to_t3_chk: assert property (@(posedge clk) disable iff (rst_i)
    phase_o == 3'd2 |=> phase_o == 3'd3);

  // R4
  ready_exit_chk: assert property (@(posedge clk) disable iff (rst_i)
    (phase_o >= 3'd3) && ready_i |=> phase_o == 3'd0);

  // R4
  wait_insert_chk: assert property (@(posedge clk) disable iff (rst_i)
    (phase_o >= 3'd3) && !ready_i |=> phase_o == 3'd4);

  // R5
  lane_hold_chk: assert property (@(posedge clk) disable iff (rst_i)
    phase_o >= 3'd2 |-> $stable({hbe_n_o, a0_o}));

  // R8
  addr_in_t1_chk: assert property (@(posedge clk) disable iff (rst_i)
    addr_phase_o |-> phase_o == 3'd1);

  // R9
  no_strap_addr_chk: assert property (@(posedge clk) disable iff (rst_i)
    (!strap_q && phase_o == 3'd1) |-> addr_phase_o);
endmodule

bind bus_lane_ctrl bus_lane_chk u_bus_lane_chk (
  .clk(clk), .rst_i(rst_i), .ready_i(ready_i), .strap_q(strap_q),
  .hbe_n_o(hbe_n_o), .a0_o(a0_o), .lane_oe_o(lane_oe_o),
  .addr_phase_o(addr_phase_o), .phase_o(phase_o)
);

// File: tb/test_bus_lane_ctrl.sv
module test_bus_lane_ctrl;
  logic clk = 0;
  logic rst_i = 1, strap_i = 0, req_i = 0, dis_lo_i = 0, dis_up_i = 0;
  logic ready_i = 1, hold_i = 0;
  logic [1:0] req_type_i = 0, region_i = 0;
  logic hbe_n_o, a0_o, lane_oe_o, addr_phase_o;
  logic [2:0] phase_o;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bus_lane_ctrl i_bus_lane_ctrl (.*);

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic s);
    @(negedge clk); rst_i = 1; strap_i = s;
    repeat (2) @(negedge clk);
    chk("R1 oe in reset", lane_oe_o, 0);
    rst_i = 0;
    @(negedge clk); #2;
    chk("R1 idle phase", phase_o, 0);
    chk("R1 idle pair", {hbe_n_o, a0_o}, 2);
    chk("R1 oe after reset", lane_oe_o, 1);
  endtask

  task automatic run_cycle(input logic [1:0] ty, input logic [1:0] rg,
                           input int waits, input int exp_addr);
    @(negedge clk);
    req_i = 1; req_type_i = ty; region_i = rg;
    @(negedge clk); #2;
    req_i = 0; req_type_i = ~ty; region_i = ~rg;
    ready_i = (waits == 0);
    chk("R2 T1", phase_o, 1);
    chk("R3 pair in T1", {hbe_n_o, a0_o}, ty);
    chk("R8 R9 addr phase", addr_phase_o, exp_addr);
    @(negedge clk); #2;
    chk("R2 T2", phase_o, 2);
    chk("R8 addr off in T2", addr_phase_o, 0);
    chk("R5 pair in T2", {hbe_n_o, a0_o}, ty);
    @(negedge clk); #2;
    chk("R2 T3", phase_o, 3);
    chk("R5 pair in T3", {hbe_n_o, a0_o}, ty);
    for (int w = 0; w < waits; w++) begin
      @(negedge clk); #2;
      ready_i = (w == waits - 1);
      chk("R4 wait phase", phase_o, 4);
      chk("R5 pair in wait", {hbe_n_o, a0_o}, ty);
    end
    @(negedge clk); #2;
    ready_i = 1;
    chk("R4 back to idle", phase_o, 0);
    chk("R1 idle pair after cycle", {hbe_n_o, a0_o}, 2);
  endtask

  initial begin
    do_reset(0);
    for (int t = 0; t < 4; t++)
      for (int w = 0; w < 3; w++)
        run_cycle(t[1:0], 2'd0, w, 1);

    // R2 request during a cycle ignored: hold req high through cycle
    @(negedge clk); req_i = 1; req_type_i = 2'd1;
    @(negedge clk); #2; chk("R2 accepted", phase_o, 1);
    @(negedge clk); #2; chk("R2 ignored in T2", phase_o, 2);
    @(negedge clk); #2; chk("R2 ignored in T3", phase_o, 3);
    req_i = 0;
    @(negedge clk); #2; chk("R2 idle after", phase_o, 0);

    // R6 hold
    @(negedge clk); hold_i = 1; req_i = 1; req_type_i = 2'd3;
    @(negedge clk); #2;
    chk("R6 oe released", lane_oe_o, 0);
    chk("R6 no start in hold", phase_o, 0);
    @(negedge clk); #2;
    chk("R6 still idle", phase_o, 0);
    hold_i = 0;
    @(negedge clk); #2;
    chk("R6 oe back", lane_oe_o, 1);
    chk("R6 no start on release edge", phase_o, 0);
    @(negedge clk); #2;
    req_i = 0;
    chk("R6 start after release", phase_o, 1);
    chk("R3 refresh pair", {hbe_n_o, a0_o}, 3);
    repeat (3) @(negedge clk);

    // R8 R9 strap x region x disable bits
    for (int s = 0; s < 2; s++) begin
      do_reset(s[0]);
      for (int r = 0; r < 4; r++)
        for (int d = 0; d < 4; d++) begin
          dis_lo_i = d[0]; dis_up_i = d[1];
          run_cycle(2'(r), 2'(r), 0,
                    (s == 1 && ((r == 1 && d[0]) || (r == 2 && d[1]))) ? 0 : 1);
        end
    end

    // R7 strap change after reset ignored
    do_reset(1);
    strap_i = 0; dis_lo_i = 1; dis_up_i = 1;
    run_cycle(2'd0, 2'd1, 1, 0);
    do_reset(0);
    strap_i = 1;
    run_cycle(2'd0, 2'd2, 0, 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule